// File: doc/BRIEF.md
# FIFO Threshold Event Status

This block produces the event flags and the interrupt for a byte-oriented I2C master. It watches the fill levels of the transmit and receive byte FIFOs during a transfer. It compares each level with a threshold set by software, and compares the bytes still to be moved with the same threshold. From these comparisons it raises a "ready" flag when a normal burst of data can be moved. It raises a separate "draining" flag when the transfer is ending and the threshold can no longer be reached.

Pulses from the bus side add three more flags: transfer complete, no acknowledge and arbitration lost. Software clears any flag by writing a one to its bit. An enable mask decides which flags drive the interrupt line. A raw view of the status also shows whether the bus is busy. The block also issues one-cycle flush strobes for the two FIFOs.

The FIFO storage and the serial shifter sit outside this block. The block only sees their levels and a count of the bytes left in the transfer.

Top module: `fifo_event_status`

## Requirements
- R1: Write select 0 loads the buffer-control register. Data bits [5:0] hold the TX threshold minus one and bits [13:8] hold the RX threshold minus one, so a field value of 63 means a threshold of 64. After reset both thresholds are 1.
- R2: While a transmit transfer is active, status bit 4 (TX ready) sets when `tx_level` < TX threshold and `bytes_left` >= TX threshold.
- R3: While a transmit transfer is active, status bit 6 (TX draining) sets instead of bit 4 when `tx_level` < TX threshold and 0 < `bytes_left` < TX threshold. Neither bit sets when `bytes_left` is 0.
- R4: While a receive transfer is active, status bit 3 (RX ready) sets when `rx_level` >= RX threshold.
- R5: While a receive transfer is active, status bit 5 (RX draining) sets when `bytes_left` is 0 and 0 < `rx_level` < RX threshold.
- R6: The pulses set these status bits: `done_pulse` sets bit 2, `nack_pulse` sets bit 1 and `al_pulse` sets bit 0. Each pulse is visible on `status_o` one clock after it is sampled.
- R7: Write select 1 clears every status bit whose data bit is 1 and leaves all other bits unchanged. Status is zero after reset.
- R8: When a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: Write select 2 loads the 7-bit interrupt enable, which is zero after reset. `irq_o` is registered: it is the OR of (status AND enable) one clock later.
- R10: `raw_status_o` bit 7 shows `bus_busy` one clock late, and bits [6:0] equal the status. The busy bit never reaches `irq_o` or `status_o`.
- R11: Data bit 6 of a buffer-control write gives a one-cycle `tx_flush_o` pulse, and data bit 14 gives a one-cycle `rx_flush_o` pulse. Neither bit is stored.
- R12: The data flags (bits 3 to 6) set only while `xfer_active` is 1, and only for the direction that `dir_tx` selects (1 means transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_level | input | LVL_W | Bytes held in the TX FIFO |
| rx_level | input | LVL_W | Bytes held in the RX FIFO |
| bytes_left | input | CNT_W | Bytes of the transfer not yet moved |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| xfer_active | input | 1 | A transfer is in progress |
| done_pulse | input | 1 | Byte count completed |
| nack_pulse | input | 1 | No acknowledge seen |
| al_pulse | input | 1 | Arbitration lost |
| bus_busy | input | 1 | Bus busy level |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 buffer-control, 1 status clear, 2 enable |
| reg_wr_data | input | 16 | Write data |
| status_o | output | 7 | Status flags |
| raw_status_o | output | 8 | Status plus busy in bit 7 |
| irq_o | output | 1 | Interrupt line |
| tx_flush_o | output | 1 | TX FIFO flush strobe |
| rx_flush_o | output | 1 | RX FIFO flush strobe |

## Verification
A flag being set and a software write-one-to-clear can land on the same clock edge. The bench provokes this by driving `nack_pulse` in the same cycle as a clear of both the no-acknowledge and arbitration-lost bits. It then expects the no-acknowledge bit to stay set and the arbitration-lost bit to go to zero.

An enable write and a pending status bit can also meet. The interrupt is then judged cycle by cycle: the line must still show the old mask for one clock, and must follow the new mask on the next.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int ST_W   = 7;
  localparam int RAW_W  = 8;
  localparam int REG_W  = 16;
  localparam int THR_W  = 6;
  localparam int B_AL   = 0;
  localparam int B_NACK = 1;
  localparam int B_ARDY = 2;
  localparam int B_RRDY = 3;
  localparam int B_XRDY = 4;
  localparam int B_RDR  = 5;
  localparam int B_XDR  = 6;
  localparam int TXT_LSB   = 0;
  localparam int RXT_LSB   = 8;
  localparam int TXCLR_BIT = 6;
  localparam int RXCLR_BIT = 14;

  typedef enum logic [1:0] {
    SEL_BUFCTL  = 2'd0,
    SEL_STATCLR = 2'd1,
    SEL_IRQEN   = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/fes_cfg_regs.sv
module fes_cfg_regs
  import fes_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [THR_W-1:0] tx_thr_m1,
  output logic [THR_W-1:0] rx_thr_m1,
  output logic [ST_W-1:0]  irq_en,
  output logic [ST_W-1:0]  st_clr,
  output logic             tx_flush,
  output logic             rx_flush
);
  logic wr_buf, wr_clr, wr_en_reg;
  logic unused_bits;

  assign wr_buf    = wr_en && (reg_sel_e'(wr_sel) == SEL_BUFCTL);
  assign wr_clr    = wr_en && (reg_sel_e'(wr_sel) == SEL_STATCLR);
  assign wr_en_reg = wr_en && (reg_sel_e'(wr_sel) == SEL_IRQEN);
  assign st_clr    = wr_clr ? wr_data[ST_W-1:0] : '0;
  assign unused_bits = ^{wr_data[7], wr_data[15]};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_thr_m1 <= '0;
      rx_thr_m1 <= '0;
      irq_en    <= '0;
      tx_flush  <= 1'b0;
      rx_flush  <= 1'b0;
    end else begin
      tx_flush <= wr_buf && wr_data[TXCLR_BIT];
      rx_flush <= wr_buf && wr_data[RXCLR_BIT];
      if (wr_buf) begin
        tx_thr_m1 <= wr_data[TXT_LSB +: THR_W];
        rx_thr_m1 <= wr_data[RXT_LSB +: THR_W];
      end
      if (wr_en_reg) irq_en <= wr_data[ST_W-1:0];
    end
  end

  a_r11_flush_one_shot: assert property (@(posedge clk) disable iff (rst)
    tx_flush |-> $past(wr_en && wr_sel == 2'd0 && wr_data[TXCLR_BIT]));
  a_r11_rx_flush_one_shot: assert property (@(posedge clk) disable iff (rst)
    rx_flush |-> $past(wr_en && wr_sel == 2'd0 && wr_data[RXCLR_BIT]));
endmodule

// File: rtl/fes_level_eval.sv
module fes_level_eval #(
  parameter int LVL_W = 4,
  parameter int CNT_W = 8,
  parameter int THR_W = 6,
  parameter bit IS_TX = 1'b1
) (
  input  logic             active,
  input  logic [LVL_W-1:0] level,
  input  logic [CNT_W-1:0] left,
  input  logic [THR_W-1:0] thr_m1,
  output logic             ready_o,
  output logic             drain_o
);
  localparam int A_W   = (LVL_W > CNT_W) ? LVL_W : CNT_W;
  localparam int CMP_W = ((A_W > THR_W) ? A_W : THR_W) + 1;

  logic [CMP_W-1:0] lv, lf, th;
  assign lv = CMP_W'(level);
  assign lf = CMP_W'(left);
  assign th = CMP_W'(thr_m1) + CMP_W'(1);

  generate
    if (IS_TX) begin : g_tx
      logic below;
      assign below   = lv < th;
      assign ready_o = active && below && (lf >= th);
      assign drain_o = active && below && (lf != '0) && (lf < th);
    end else begin : g_rx
      assign ready_o = active && (lv >= th);
      assign drain_o = active && (lf == '0) && (lv != '0) && (lv < th);
    end
  endgenerate
endmodule

// File: rtl/fes_flag_bank.sv
module fes_flag_bank #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst)           q_o[i] <= 1'b0;
        else if (set_i[i]) q_o[i] <= 1'b1;
        else if (clr_i[i]) q_o[i] <= 1'b0;
      end

      a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i[i] |=> q_o[i]);
      a_r7_clear_one: assert property (@(posedge clk) disable iff (rst)
        (!set_i[i] && clr_i[i]) |=> !q_o[i]);
      a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_i[i] && !clr_i[i]) |=> (q_o[i] == $past(q_o[i])));
    end
  endgenerate
endmodule

// File: rtl/fifo_event_status.sv
module fifo_event_status
  import fes_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int CNT_W      = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic [CNT_W-1:0]   bytes_left,
  input  logic               dir_tx,
  input  logic               xfer_active,
  input  logic               done_pulse,
  input  logic               nack_pulse,
  input  logic               al_pulse,
  input  logic               bus_busy,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_wr_sel,
  input  logic [REG_W-1:0]   reg_wr_data,
  output logic [ST_W-1:0]    status_o,
  output logic [RAW_W-1:0]   raw_status_o,
  output logic               irq_o,
  output logic               tx_flush_o,
  output logic               rx_flush_o
);
  logic [THR_W-1:0] tx_thr_m1, rx_thr_m1;
  logic [ST_W-1:0]  irq_en, st_clr, st_set, st_q;
  logic             tx_rdy, tx_drn, rx_rdy, rx_drn;
  logic             busy_q, irq_q;

  fes_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_sel(reg_wr_sel),
    .wr_data(reg_wr_data), .tx_thr_m1(tx_thr_m1), .rx_thr_m1(rx_thr_m1),
    .irq_en(irq_en), .st_clr(st_clr), .tx_flush(tx_flush_o),
    .rx_flush(rx_flush_o)
  );

  fes_level_eval #(.LVL_W(LVL_W), .CNT_W(CNT_W), .THR_W(THR_W), .IS_TX(1'b1)) u_tx_eval (
    .active(xfer_active && dir_tx), .level(tx_level), .left(bytes_left),
    .thr_m1(tx_thr_m1), .ready_o(tx_rdy), .drain_o(tx_drn)
  );

  fes_level_eval #(.LVL_W(LVL_W), .CNT_W(CNT_W), .THR_W(THR_W), .IS_TX(1'b0)) u_rx_eval (
    .active(xfer_active && !dir_tx), .level(rx_level), .left(bytes_left),
    .thr_m1(rx_thr_m1), .ready_o(rx_rdy), .drain_o(rx_drn)
  );

  always_comb begin
    st_set         = '0;
    st_set[B_AL]   = al_pulse;
    st_set[B_NACK] = nack_pulse;
    st_set[B_ARDY] = done_pulse;
    st_set[B_RRDY] = rx_rdy;
    st_set[B_XRDY] = tx_rdy;
    st_set[B_RDR]  = rx_drn;
    st_set[B_XDR]  = tx_drn;
  end

  fes_flag_bank #(.W(ST_W)) u_flags (
    .clk(clk), .rst(rst), .set_i(st_set), .clr_i(st_clr), .q_o(st_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= bus_busy;
      irq_q  <= |(st_q & irq_en);
    end
  end

  assign status_o     = st_q;
  assign raw_status_o = {busy_q, st_q};
  assign irq_o        = irq_q;

  a_r10_busy_raw: assert property (@(posedge clk) disable iff (rst)
    raw_status_o[RAW_W-1] == $past(bus_busy));
  a_r6_nack_sets: assert property (@(posedge clk) disable iff (rst)
    nack_pulse |=> status_o[B_NACK]);
  a_r6_done_sets: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> status_o[B_ARDY]);
  a_r12_tx_rx_apart: assert property (@(posedge clk) disable iff (rst)
    !((tx_rdy || tx_drn) && (rx_rdy || rx_drn)));
endmodule

// File: tb/fifo_event_status_tb_top.sv
module fifo_event_status_tb_top;
  localparam int FIFO_DEPTH = 8;
  localparam int CNT_W      = 8;
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LVL_W-1:0] tx_level = '0, rx_level = '0;
  logic [CNT_W-1:0] bytes_left = '0;
  logic dir_tx = 1'b0, xfer_active = 1'b0;
  logic done_pulse = 1'b0, nack_pulse = 1'b0, al_pulse = 1'b0, bus_busy = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [1:0] reg_wr_sel = 2'd3;
  logic [15:0] reg_wr_data = '0;
  logic [6:0] status_o;
  logic [7:0] raw_status_o;
  logic irq_o, tx_flush_o, rx_flush_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fifo_event_status #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .tx_level(tx_level), .rx_level(rx_level),
    .bytes_left(bytes_left), .dir_tx(dir_tx), .xfer_active(xfer_active),
    .done_pulse(done_pulse), .nack_pulse(nack_pulse), .al_pulse(al_pulse),
    .bus_busy(bus_busy), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .status_o(status_o), .raw_status_o(raw_status_o),
    .irq_o(irq_o), .tx_flush_o(tx_flush_o), .rx_flush_o(rx_flush_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one register write, effective at the edge after this negedge
  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_sel = 2'd3; reg_wr_data = '0;
  endtask

  task automatic set_thr(input int ttx, input int trx);
    wr(2'd0, {2'b00, 6'(trx - 1), 2'b00, 6'(ttx - 1)});
  endtask

  function automatic logic [6:0] expect_vec(input bit tx, input int thr, input int lvl, input int left);
    logic [6:0] e = '0;
    if (tx) begin
      e[4] = (lvl < thr) && (left >= thr);
      e[6] = (lvl < thr) && (left != 0) && (left < thr);
    end else begin
      e[3] = (lvl >= thr);
      e[5] = (left == 0) && (lvl != 0) && (lvl < thr);
    end
    return e;
  endfunction

  // one cycle of activity, then check and clear everything
  task automatic apply(input bit tx, input int thr, input int lvl, input int left, input string req);
    @(negedge clk);
    xfer_active = 1'b1; dir_tx = tx; bytes_left = CNT_W'(left);
    if (tx) begin tx_level = LVL_W'(lvl); rx_level = LVL_W'(FIFO_DEPTH); end
    else    begin rx_level = LVL_W'(lvl); tx_level = '0; end
    @(negedge clk);
    xfer_active = 1'b0;
    chk(req, 32'(status_o), 32'(expect_vec(tx, thr, lvl, left)));
    reg_wr_en = 1'b1; reg_wr_sel = 2'd1; reg_wr_data = 16'h007F;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_sel = 2'd3; reg_wr_data = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 R9 reset state
    chk("R7 reset status", 32'(status_o), 0);
    chk("R9 reset irq", 32'(irq_o), 0);
    // R1 reset threshold is 1: TX level 0, two bytes left -> ready
    apply(1'b1, 1, 0, 2, "R1 reset thr");

    // sweep thresholds, levels, counts, both directions (R2 R3 R4 R5 R12)
    for (int t = 1; t <= FIFO_DEPTH; t++) begin
      set_thr(t, t);
      for (int l = 0; l <= FIFO_DEPTH; l++)
        for (int b = 0; b <= 10; b++) begin
          apply(1'b1, t, l, b, "R2/R3 tx sweep");
          apply(1'b0, t, l, b, "R4/R5 rx sweep");
        end
      // R1 field independence: RX field different from TX field
      set_thr(t, FIFO_DEPTH + 1 - t);
      apply(1'b0, FIFO_DEPTH + 1 - t, t, 0, "R1 rx field");
      apply(1'b1, t, t - 1, t, "R1 tx field");
    end

    // R1 field top value 63 -> threshold 64
    set_thr(64, 64);
    apply(1'b1, 64, 8, 100, "R1 thr64 ready");
    apply(1'b1, 64, 8, 10, "R3 thr64 drain");
    apply(1'b0, 64, 8, 0, "R5 thr64 drain");

    // R12 inactive: conditions true but xfer_active low
    set_thr(4, 4);
    @(negedge clk);
    dir_tx = 1'b1; tx_level = '0; bytes_left = 8'd20; xfer_active = 1'b0;
    @(negedge clk);
    chk("R12 idle no flags", 32'(status_o), 0);

    // R6 pulses
    @(negedge clk); done_pulse = 1'b1;
    @(negedge clk); done_pulse = 1'b0;
    chk("R6 done bit2", 32'(status_o), 32'h04);
    @(negedge clk); al_pulse = 1'b1; nack_pulse = 1'b1;
    @(negedge clk); al_pulse = 1'b0; nack_pulse = 1'b0;
    chk("R6 al nack", 32'(status_o), 32'h07);

    // R7 partial clear
    wr(2'd1, 16'h0004);
    chk("R7 partial clear", 32'(status_o), 32'h03);

    // R8 set wins: NACK pulse alongside clear of NACK and AL
    @(negedge clk);
    nack_pulse = 1'b1; reg_wr_en = 1'b1; reg_wr_sel = 2'd1; reg_wr_data = 16'h0003;
    @(negedge clk);
    nack_pulse = 1'b0; reg_wr_en = 1'b0; reg_wr_sel = 2'd3; reg_wr_data = '0;
    chk("R8 set beats clear", 32'(status_o), 32'h02);

    // R9 interrupt timing and masking; NACK pending
    chk("R9 masked off", 32'(irq_o), 0);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 16'h0002;
    @(negedge clk); reg_wr_en = 1'b0; reg_wr_sel = 2'd3; reg_wr_data = '0;
    chk("R9 one cycle late", 32'(irq_o), 0);
    @(negedge clk);
    chk("R9 irq up", 32'(irq_o), 1);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_sel = 2'd2; reg_wr_data = 16'h0001;
    @(negedge clk); reg_wr_en = 1'b0; reg_wr_sel = 2'd3; reg_wr_data = '0;
    chk("R9 old mask held", 32'(irq_o), 1);
    @(negedge clk);
    chk("R9 new mask", 32'(irq_o), 0);
    wr(2'd1, 16'h007F);
    wr(2'd2, 16'h007F);
    @(negedge clk);

    // R10 busy bit
    bus_busy = 1'b1;
    @(negedge clk);
    chk("R10 raw busy", 32'(raw_status_o), 32'h80);
    chk("R10 status clean", 32'(status_o), 0);
    @(negedge clk);
    chk("R10 no irq", 32'(irq_o), 0);
    bus_busy = 1'b0;
    @(negedge clk);
    chk("R10 raw idle", 32'(raw_status_o), 0);

    // R11 flush strobes, thresholds stay at 4
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 16'h0343;
    @(negedge clk); reg_wr_en = 1'b0; reg_wr_sel = 2'd3; reg_wr_data = '0;
    chk("R11 tx flush", 32'({tx_flush_o, rx_flush_o}), 32'h2);
    @(negedge clk);
    chk("R11 tx flush gone", 32'({tx_flush_o, rx_flush_o}), 0);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 16'h4303;
    @(negedge clk); reg_wr_en = 1'b0; reg_wr_sel = 2'd3; reg_wr_data = '0;
    chk("R11 rx flush", 32'({tx_flush_o, rx_flush_o}), 32'h1);
    @(negedge clk);
    chk("R11 rx flush gone", 32'({tx_flush_o, rx_flush_o}), 0);
    apply(1'b1, 4, 3, 4, "R11 tx thr kept");
    apply(1'b0, 4, 3, 0, "R11 rx thr kept");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule